// File: doc/BRIEF.md
# Predicated Execute Unit with Condition Flag

This block is the execute stage of a small 8-bit processor. Each cycle it may accept one issued instruction byte together with two operands that earlier logic has already resolved. All arithmetic and logic results, and all four comparisons, are computed side by side. The opcode then picks the one that applies. Arithmetic and logic results are registered and presented with a write-enable one cycle after issue. Comparisons produce no register result. Instead they load a single condition flag that later instructions can depend on.

Every instruction carries two predicate bits. One makes it run only while the flag is set. The other makes it run only while the flag is clear. With neither bit set, the instruction always runs. If both are set the encoding is illegal, and the block emits a one-cycle halt strobe. Comparisons obey the predicate like any other instruction, so a compare that is suppressed leaves the flag untouched. A chain of flag-set-predicated compares therefore computes the AND of all its tests.

Top module: `pex_exec`

## Requirements
- R1: An instruction is taken only in a cycle where `issue_valid` is high. Its byte is decoded as bit 7 = run-if-set, bit 6 = run-if-clear, bits 5:4 = length, bits 3:0 = opcode. A cycle without issue gives `wr_en` = 0 and `halt` = 0 on the next cycle.
- R2: With a nonzero length and a passing predicate, opcodes 0, 1, 5, 6 and 7 (add, sub, and, or, xor) register their result on `result` and pulse `wr_en` for one cycle after issue. Add and sub wrap modulo 256.
- R3: Opcode 2 (mul) returns the low 8 bits of the product. Opcode 3 (div) returns the unsigned quotient A/B, and 0xFF when B is 0, with no error indication.
- R4: Opcode 4 (not) returns the bitwise inverse of operand A and ignores operand B.
- R5: With bit 7 set, an instruction executes only when the flag is 1. With bit 6 set, it executes only when the flag is 0. With both clear, it always executes. A suppressed instruction gives `wr_en` = 0.
- R6: An issued byte with bits 7 and 6 both set raises `halt` for exactly one cycle on the next cycle. It writes nothing and leaves the flag unchanged.
- R7: With a nonzero length and a passing predicate, opcodes 12 to 15 compare A with B and load the flag at the next edge. The tests are: 12 = equal, 13 = unsigned less-than, 14 = signed less-than, 15 = signed less-or-equal. These opcodes never assert `wr_en`.
- R8: The flag changes only through a compare that actually executes. A suppressed compare leaves it as it was, so an equality test followed by a bit-7-predicated equality test leaves the flag at 1 only when both tests are true.
- R9: Length 00 (control class) with any opcode, and opcodes 8 to 11 (memory class) with any length, produce no write and no flag change here.
- R10: During and right after reset, `cond_flag`, `wr_en`, `halt` and `result` are all 0.
- R11: `result` keeps its last written value through every cycle in which no write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 8 | Instruction byte (predicate, length, opcode) |
| opnd_a | input | 8 | Resolved first operand |
| opnd_b | input | 8 | Resolved second operand |
| result | output | 8 | Registered ALU result |
| wr_en | output | 1 | One-cycle write strobe for `result` |
| cond_flag | output | 1 | Condition flag |
| halt | output | 1 | One-cycle strobe on an illegal predicate pair |

## Verification
The bench targets five corner cases.

- Sign handling in compares: 0x80 against 0x01 must give opposite answers for the unsigned and signed less-than tests. A unit that mixed up the two would leave the wrong flag.
- Division by zero: a missing guard would return an arbitrary quotient instead of 0xFF.
- Compare chains: a suppressed compare that still loaded the flag would break the AND, and show up as a flag set after a failed first test.
- The illegal predicate pair: it is checked for a halt strobe, for no write and for an unchanged flag.
- Control-class and memory-class bytes that carry compare or ALU opcodes: a decoder that ignored the length field or the memory class would write a result or load the flag.

// File: rtl/pex_pkg.sv
package pex_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_MUL = 4'd2,
      OP_DIV = 4'd3,
      OP_NOT = 4'd4,
      OP_AND = 4'd5,
      OP_OR  = 4'd6,
      OP_XOR = 4'd7,
      OP_CEQ = 4'd12,
      OP_CLU = 4'd13,
      OP_CLS = 4'd14,
      OP_CLE = 4'd15
   } pex_op_e;

   typedef enum logic [1:0] {
      CMP_EQ  = 2'd0,
      CMP_LTU = 2'd1,
      CMP_LTS = 2'd2,
      CMP_LE  = 2'd3
   } pex_cmp_e;

   typedef enum logic [1:0] {
      CLS_ALU,
      CLS_MEM,
      CLS_CMP,
      CLS_CTRL
   } pex_class_e;

endpackage

// File: rtl/pex_alu.sv
module pex_alu #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   localparam int N_RES  = 1 << SEL_W;
   localparam int PROD_W = 2 * DATA_W;

   logic [DATA_W-1:0] res [N_RES];
   logic [PROD_W-1:0] prod;

   if (SEL_W != 3) begin : g_bad_sel
      $error("pex_alu: SEL_W must be 3");
   end

   always_comb begin
      prod   = PROD_W'(a) * PROD_W'(b);
      res[0] = a + b;
      res[1] = a - b;
      res[2] = prod[DATA_W-1:0];
      res[3] = (b == '0) ? {DATA_W{1'b1}} : (a / b);
      res[4] = ~a;
      res[5] = a & b;
      res[6] = a | b;
      res[7] = a ^ b;
   end

   assign y = res[sel];

endmodule

// File: rtl/pex_cmp.sv
module pex_cmp #(
   parameter int DATA_W    = 8,
   parameter bit SIGNED_LE = 1'b1
) (
   input  pex_pkg::pex_cmp_e  kind,
   input  logic [DATA_W-1:0]  a,
   input  logic [DATA_W-1:0]  b,
   output logic               hit
);
   import pex_pkg::*;

   logic is_eq, is_ltu, is_lts, is_le;

   assign is_eq  = (a == b);
   assign is_ltu = (a < b);
   assign is_lts = ($signed(a) < $signed(b));

   if (SIGNED_LE) begin : g_le_signed
      assign is_le = is_lts | is_eq;
   end else begin : g_le_unsigned
      assign is_le = is_ltu | is_eq;
   end

   always_comb begin
      unique case (kind)
         CMP_EQ:  hit = is_eq;
         CMP_LTU: hit = is_ltu;
         CMP_LTS: hit = is_lts;
         default: hit = is_le;
      endcase
   end

endmodule

// File: rtl/pex_pred.sv
module pex_pred (
   input  logic on_set,
   input  logic on_clear,
   input  logic flag,
   output logic run,
   output logic fault
);
   assign fault = on_set & on_clear;
   always_comb begin
      unique case ({on_set, on_clear})
         2'b00:   run = 1'b1;
         2'b10:   run = flag;
         2'b01:   run = ~flag;
         default: run = 1'b0;
      endcase
   end
endmodule

// File: rtl/pex_exec.sv
module pex_exec #(
   parameter int DATA_W    = 8,
   parameter int LEN_W     = 2,
   parameter int OP_W      = 4,
   parameter bit SIGNED_LE = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           issue_valid,
   input  logic [2+LEN_W+OP_W-1:0]        instr,
   input  logic [DATA_W-1:0]              opnd_a,
   input  logic [DATA_W-1:0]              opnd_b,
   output logic [DATA_W-1:0]              result,
   output logic                           wr_en,
   output logic                           cond_flag,
   output logic                           halt
);
   import pex_pkg::*;

   localparam int INSTR_W = 2 + LEN_W + OP_W;
   localparam int BIT_SET = INSTR_W - 1;
   localparam int BIT_CLR = INSTR_W - 2;
   localparam int SEL_W   = OP_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("pex_exec: DATA_W must be at least 2");
   end
   if (OP_W != 4) begin : g_bad_op
      $error("pex_exec: OP_W must be 4");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("pex_exec: LEN_W must be at least 1");
   end

   logic [LEN_W-1:0]  len_f;
   logic [OP_W-1:0]   op_f;
   logic              run, fault;
   logic [DATA_W-1:0] alu_y;
   logic              cmp_hit;
   pex_class_e        cls;

   assign len_f = instr[OP_W +: LEN_W];
   assign op_f  = instr[OP_W-1:0];

   always_comb begin
      if (len_f == '0)                 cls = CLS_CTRL;
      else if (!op_f[OP_W-1])          cls = CLS_ALU;
      else if (op_f[OP_W-2])           cls = CLS_CMP;
      else                             cls = CLS_MEM;
   end

   pex_pred u_pred (
      .on_set   (instr[BIT_SET]),
      .on_clear (instr[BIT_CLR]),
      .flag     (cond_flag),
      .run      (run),
      .fault    (fault)
   );

   pex_alu #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_alu (
      .sel (op_f[SEL_W-1:0]),
      .a   (opnd_a),
      .b   (opnd_b),
      .y   (alu_y)
   );

   pex_cmp #(.DATA_W(DATA_W), .SIGNED_LE(SIGNED_LE)) u_cmp (
      .kind (pex_cmp_e'(op_f[1:0])),
      .a    (opnd_a),
      .b    (opnd_b),
      .hit  (cmp_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result    <= '0;
         wr_en     <= 1'b0;
         cond_flag <= 1'b0;
         halt      <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         halt  <= 1'b0;
         if (issue_valid) begin
            if (fault) begin
               halt <= 1'b1;
            end else if (run) begin
               if (cls == CLS_ALU) begin
                  wr_en  <= 1'b1;
                  result <= alu_y;
               end else if (cls == CLS_CMP) begin
                  cond_flag <= cmp_hit;
               end
            end
         end
      end
   end

endmodule

// File: rtl/pex_checks.sv
module pex_checks (
   input logic       clk,
   input logic       rst_n,
   input logic       issue_valid,
   input logic [7:0] instr,
   input logic [7:0] result,
   input logic       wr_en,
   input logic       cond_flag,
   input logic       halt
);
   logic pass_now;
   assign pass_now = (!instr[7] && !instr[6]) || (instr[7] && !instr[6] && cond_flag)
                   || (!instr[7] && instr[6] && !cond_flag);

   // R1
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> (!wr_en && !halt));

   // R5
   p_pred_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !pass_now) |=> !wr_en);

   // R6
   p_bad_pred_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && instr[7] && instr[6]) |=> (halt && !wr_en && $stable(cond_flag)));

   // R8
   p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_valid && pass_now && instr[5:4] != 2'b00 && instr[3:2] == 2'b11)
      |=> $stable(cond_flag));

   // R9
   p_no_write_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && (instr[5:4] == 2'b00 || instr[3])) |=> !wr_en);

   // R11
   p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> $stable(result));

   // R6: halt and write never coincide
   p_halt_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> !wr_en);

endmodule

bind pex_exec pex_checks u_pex_checks (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .instr       (instr),
   .result      (result),
   .wr_en       (wr_en),
   .cond_flag   (cond_flag),
   .halt        (halt)
);

// File: tb/sim_pex_exec.sv
module sim_pex_exec;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       issue_valid = 1'b0;
   logic [7:0] instr = '0;
   logic [7:0] opnd_a = '0;
   logic [7:0] opnd_b = '0;
   logic [7:0] result;
   logic       wr_en, cond_flag, halt;

   always #2 clk = ~clk;

   pex_exec u0 (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .wr_en(wr_en),
      .cond_flag(cond_flag), .halt(halt)
   );

   typedef struct {
      logic       wr;
      logic [7:0] res;
      logic       flag;
      logic       hlt;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   errors = 0;
   int   checks = 0;
   logic       m_flag = 1'b0;
   logic [7:0] m_res = '0;
   bit   done = 0;

   task automatic check_item(input exp_t e);
      checks++;
      if (wr_en !== e.wr || result !== e.res || cond_flag !== e.flag || halt !== e.hlt) begin
         errors++;
         $display("FAIL %s: got wr=%0b res=%02h flag=%0b halt=%0b expected wr=%0b res=%02h flag=%0b halt=%0b",
                  e.tag, wr_en, result, cond_flag, halt, e.wr, e.res, e.flag, e.hlt);
      end
   endtask

   // monitor: one expected item per issued cycle
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) check_item(q.pop_front());
      end
   end

   function automatic logic [7:0] model_alu(input logic [2:0] s, input logic [7:0] a, b);
      logic [15:0] p;
      p = a * b;
      case (s)
         3'd0: return 8'((a + b) % 256);
         3'd1: return 8'((a + 256 - b) % 256);
         3'd2: return p[7:0];
         3'd3: return (b == 0) ? 8'hFF : 8'(a / b);
         3'd4: return 8'hFF ^ a;
         3'd5: return a & b;
         3'd6: return a | b;
         default: return a ^ b;
      endcase
   endfunction

   function automatic logic model_cmp(input logic [1:0] k, input logic [7:0] a, b);
      int sa, sb;
      sa = (a >= 128) ? int'(a) - 256 : int'(a);
      sb = (b >= 128) ? int'(b) - 256 : int'(b);
      case (k)
         2'd0: return a == b;
         2'd1: return a < b;
         2'd2: return sa < sb;
         default: return sa <= sb;
      endcase
   endfunction

   task automatic issue(input logic c, n, input logic [1:0] len, input logic [3:0] op,
                        input logic [7:0] a, b, input string tag);
      exp_t e;
      logic run;
      run = (!c && !n) || (c && !n && m_flag) || (!c && n && !m_flag);
      e.wr = 0; e.hlt = 0;
      if (c && n) e.hlt = 1;
      else if (run && len != 0 && !op[3]) begin
         e.wr = 1; m_res = model_alu(op[2:0], a, b);
      end else if (run && len != 0 && op[3:2] == 2'b11) begin
         m_flag = model_cmp(op[1:0], a, b);
      end
      e.res = m_res; e.flag = m_flag; e.tag = tag;
      @(negedge clk);
      issue_valid = 1; instr = {c, n, len, op}; opnd_a = a; opnd_b = b;
      q.push_back(e);
   endtask

   task automatic idle(input string tag);
      exp_t e;
      e.wr = 0; e.hlt = 0; e.res = m_res; e.flag = m_flag; e.tag = tag;
      @(negedge clk);
      issue_valid = 0; instr = 8'hFF; opnd_a = 8'h5A; opnd_b = 8'hA5;
      q.push_back(e);
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got running expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (result !== 0 || wr_en !== 0 || cond_flag !== 0 || halt !== 0) begin
         errors++;
         $display("FAIL R10: got res=%02h wr=%0b flag=%0b halt=%0b expected all zero",
                  result, wr_en, cond_flag, halt);
      end
      rst_n = 1;
      // R2 arithmetic/logic with wrap
      issue(0,0,2'd3,4'd0,8'd200,8'd100,"R2 add wrap");
      issue(0,0,2'd3,4'd1,8'd5,8'd7,"R2 sub wrap");
      issue(0,0,2'd3,4'd5,8'hF0,8'h3C,"R2 and");
      issue(0,0,2'd3,4'd6,8'hF0,8'h0C,"R2 or");
      issue(0,0,2'd3,4'd7,8'hFF,8'h0F,"R2 xor");
      // R3 mul/div
      issue(0,0,2'd3,4'd2,8'd20,8'd13,"R3 mul low byte");
      issue(0,0,2'd3,4'd3,8'd200,8'd7,"R3 div");
      issue(0,0,2'd3,4'd3,8'd99,8'd0,"R3 div by zero");
      // R4 not ignores B
      issue(0,0,2'd2,4'd4,8'h0F,8'hAA,"R4 not");
      issue(0,0,2'd2,4'd4,8'h0F,8'h00,"R4 not other B");
      // R1 idle, R11 hold
      idle("R1 idle");
      idle("R11 hold");
      // R7 compares
      issue(0,0,2'd2,4'd12,8'd5,8'd5,"R7 eq");
      issue(0,0,2'd2,4'd13,8'h80,8'h01,"R7 ltu");
      issue(0,0,2'd2,4'd14,8'h80,8'h01,"R7 lt signed");
      issue(0,0,2'd2,4'd15,8'h01,8'hFF,"R7 le signed");
      issue(0,0,2'd2,4'd15,8'd3,8'd3,"R7 le equal");
      // R5 predicate with flag=1
      issue(1,0,2'd3,4'd0,8'd1,8'd2,"R5 run-if-set taken");
      issue(0,1,2'd3,4'd0,8'd9,8'd9,"R5 run-if-clear skipped");
      issue(0,0,2'd2,4'd12,8'd1,8'd2,"R7 eq false");
      issue(1,0,2'd3,4'd7,8'h11,8'h22,"R5 run-if-set skipped");
      issue(0,1,2'd3,4'd1,8'd50,8'd8,"R5 run-if-clear taken");
      // R8 chain
      issue(0,0,2'd2,4'd12,8'd1,8'd1,"R8 chain first true");
      issue(1,0,2'd2,4'd12,8'd2,8'd3,"R8 chain second false");
      issue(1,0,2'd2,4'd12,8'd4,8'd4,"R8 suppressed compare");
      issue(0,0,2'd2,4'd12,8'd0,8'd0,"R8 chain restart");
      issue(1,0,2'd2,4'd12,8'd9,8'd9,"R8 chain both true");
      // R6 illegal predicate
      issue(1,1,2'd3,4'd0,8'd1,8'd1,"R6 halt");
      issue(1,1,2'd2,4'd12,8'd1,8'd2,"R6 halt compare");
      idle("R6 strobe one cycle");
      // R9 no effect classes (flag is 1 here)
      issue(0,0,2'd0,4'd12,8'd1,8'd2,"R9 control class compare");
      issue(0,0,2'd0,4'd0,8'd3,8'd4,"R9 control class add");
      issue(0,0,2'd3,4'd9,8'd3,8'd4,"R9 memory class");
      issue(0,0,2'd2,4'd10,8'd3,8'd4,"R9 memory class push");
      idle("R11 final hold");
      idle("R1 drain");
      repeat (2) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule